// File: doc/BRIEF.md
# Bitmap and Overlay Pixel Mixer

This block merges a bitmap plane with two single-bit overlay planes, one scanline at a time. Each video word carries two 8-bit bitmap pixels. For every pixel the block produces a 9-bit palette index. A nonzero overlay code selects one of four overlay colours above the 256 bitmap colours. When the overlay code is zero, the block uses the masked bitmap pixel, or an overlay colour if the control register asks for it.

The block drives the video column address that the word feeder must serve. It also strobes when it takes a fresh byte from each overlay plane. Both output pixels of a word are presented together, one clock after the word is accepted, with a single valid strobe.

Top module: `ovl_pixel_mixer`

## Requirements
- R1: The two pixels of a 16-bit word come out in a fixed order. Bits 15:8 go to `pix_idx0`, the first pixel on screen. Bits 7:0 go to `pix_idx1`, the second pixel.
- R2: A bitmap index is the pixel byte ANDed with `read_mask`. When `ovl_ctrl` bit 5 (blink enable) is set, the bits set in `blink_mask` are also cleared from that result. Bit 8 of a bitmap index is 0.
- R3: The overlay code of a pixel is {plane 1 bit, plane 0 bit}. A nonzero code makes the index 256 + code, whatever the bitmap holds.
- R4: While `ovl_ctrl` bit 6 is clear, overlay code zero is also a colour and gives index 256. While bit 6 is set, code zero shows the bitmap index.
- R5: `ovl_ctrl` bit 2 forces all plane 0 bits to zero. `ovl_ctrl` bit 3 does the same for plane 1.
- R6: Each plane byte serves 4 consecutive active words, bits consumed from the LSB. The first pixel of a word uses the lower of each pair of bits. `ovl_fetch` is high, combinationally, in exactly those accepted active words that load a new byte from `ovl0_byte` and `ovl1_byte`.
- R7: `col_addr` increments by one for every accepted active word and wraps from 511 to 0. Reset sets it to 0.
- R8: A `line_start` pulse loads `start_col` into `col_addr` and restarts the overlay byte sequence. A word presented in the same cycle is dropped.
- R9: A word presented while `v_active` is low produces no output. It advances neither the column nor the overlay position.
- R10: A word accepted while `h_active` is low yields valid output with both indices 0. It advances neither the column nor the overlay position.
- R11: An accepted word appears on `pix_valid` and the index outputs on the clock edge after it is presented. `pix_valid` is low in every other cycle and after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_start | input | 1 | Start-of-line pulse |
| start_col | input | 9 | Starting column address of the line |
| v_active | input | 1 | Line lies inside the vertical active region |
| h_active | input | 1 | Current word lies inside the active width |
| word_valid | input | 1 | A video word is presented |
| word_data | input | 16 | Two bitmap pixels, first pixel in the high byte |
| ovl0_byte | input | 8 | Next byte of overlay plane 0 |
| ovl1_byte | input | 8 | Next byte of overlay plane 1 |
| read_mask | input | 8 | Bitmap read mask |
| blink_mask | input | 8 | Bitmap bits removed while blinking |
| ovl_ctrl | input | 8 | Overlay control: bit 2 plane 0 off, bit 3 plane 1 off, bit 5 blink enable, bit 6 zero code shows bitmap |
| col_addr | output | 9 | Column address of the next word |
| ovl_fetch | output | 1 | Overlay bytes taken this cycle |
| pix_valid | output | 1 | Index pair valid |
| pix_idx0 | output | 9 | Palette index of the first pixel |
| pix_idx1 | output | 9 | Palette index of the second pixel |

## Verification
A slipped overlay counter shows up in two places. From the next byte boundary on, `ovl_fetch` pulses on the wrong word. The overlay colours also drift sideways by a pair of pixels, within four words. A column register that fails to hold during blank or vertical-inactive words shows at `col_addr` on the next clock. A swapped lane or a mask applied in the wrong place corrupts the very next index pair. The scoreboard therefore compares every pair and the column address of every word against an independent model.

// File: rtl/mixer_pkg.sv
package mixer_pkg;
  localparam int CTL_P0_OFF     = 2;
  localparam int CTL_P1_OFF     = 3;
  localparam int CTL_BLINK_EN   = 5;
  localparam int CTL_ZERO_BMAP  = 6;
  localparam int LANES          = 2;
  localparam int PLANES         = 2;
endpackage

// File: rtl/mixer_seq.sv
module mixer_seq #(
  parameter int COL_W = 9,
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_start,
  input  logic [COL_W-1:0] start_col,
  input  logic             advance,
  output logic [COL_W-1:0] col_addr,
  output logic             slot_zero
);
  logic [COL_W-1:0] col_q, col_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             en;

  always_comb begin
    col_d = col_q;
    cnt_d = cnt_q;
    en    = line_start | advance;
    if (line_start) begin
      col_d = start_col;
      cnt_d = '0;
    end else if (advance) begin
      col_d = col_q + 1'b1;
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_q <= '0;
      cnt_q <= '0;
    end else if (en) begin
      col_q <= col_d;
      cnt_q <= cnt_d;
    end
  end

  assign col_addr  = col_q;
  assign slot_zero = (cnt_q == '0);

  AST_COL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !line_start) |=> (col_addr == $past(col_addr) + 1'b1)); // R7
  AST_LINE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    line_start |=> (col_addr == $past(start_col)) && slot_zero); // R8
  AST_COL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!advance && !line_start) |=> $stable(col_addr)); // R9
endmodule

// File: rtl/ovl_plane_shift.sv
module ovl_plane_shift #(
  parameter int BYTE_W   = 8,
  parameter int PER_WORD = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                restart,
  input  logic                advance,
  input  logic                load,
  input  logic                plane_en,
  input  logic [BYTE_W-1:0]   byte_in,
  output logic [PER_WORD-1:0] word_bits
);
  logic [BYTE_W-1:0] sh_q, sh_d, src;
  logic              en;

  always_comb begin
    src       = load ? (byte_in & {BYTE_W{plane_en}}) : sh_q;
    word_bits = src[PER_WORD-1:0];
    en        = restart | advance;
    sh_d      = restart ? '0 : (src >> PER_WORD);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  sh_q <= '0;
    else if (en) sh_q <= sh_d;
  end
endmodule

// File: rtl/pix_lane_sel.sv
module pix_lane_sel #(
  parameter int PIX_W = 8
) (
  input  logic [PIX_W-1:0] pixel,
  input  logic [PIX_W-1:0] bmask,
  input  logic [1:0]       code,
  input  logic             zero_is_colour,
  output logic [PIX_W:0]   idx
);
  always_comb begin
    if ((code != 2'b00) || zero_is_colour)
      idx = {1'b1, {(PIX_W-2){1'b0}}, code};
    else
      idx = {1'b0, pixel & bmask};
  end
endmodule

// File: rtl/ovl_pixel_mixer.sv
module ovl_pixel_mixer #(
  parameter int PIX_W  = 8,
  parameter int COL_W  = 9,
  parameter int BYTE_W = 8,
  localparam int WORD_W  = 2 * PIX_W,
  localparam int IDX_W   = PIX_W + 1,
  localparam int CNT_W   = $clog2(BYTE_W / 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_start,
  input  logic [COL_W-1:0]  start_col,
  input  logic              v_active,
  input  logic              h_active,
  input  logic              word_valid,
  input  logic [WORD_W-1:0] word_data,
  input  logic [BYTE_W-1:0] ovl0_byte,
  input  logic [BYTE_W-1:0] ovl1_byte,
  input  logic [PIX_W-1:0]  read_mask,
  input  logic [PIX_W-1:0]  blink_mask,
  input  logic [7:0]        ovl_ctrl,
  output logic [COL_W-1:0]  col_addr,
  output logic              ovl_fetch,
  output logic              pix_valid,
  output logic [IDX_W-1:0]  pix_idx0,
  output logic [IDX_W-1:0]  pix_idx1
);
  import mixer_pkg::*;

  logic             take, advance, slot_zero;
  logic [PIX_W-1:0] bmask;
  logic             zero_colour;
  logic [1:0]       pbits [PLANES];
  logic [BYTE_W-1:0] pbyte [PLANES];
  logic             pen   [PLANES];
  logic [IDX_W-1:0] lane_idx [LANES];
  logic             valid_d;
  logic [IDX_W-1:0] idx0_d, idx1_d;
  logic             valid_q;
  logic [IDX_W-1:0] idx0_q, idx1_q;

  assign take        = word_valid & v_active & ~line_start;
  assign advance     = take & h_active;
  assign zero_colour = ~ovl_ctrl[CTL_ZERO_BMAP];
  assign bmask       = ovl_ctrl[CTL_BLINK_EN] ? (read_mask & ~blink_mask) : read_mask;
  assign pbyte[0]    = ovl0_byte;
  assign pbyte[1]    = ovl1_byte;
  assign pen[0]      = ~ovl_ctrl[CTL_P0_OFF];
  assign pen[1]      = ~ovl_ctrl[CTL_P1_OFF];

  mixer_seq #(.COL_W(COL_W), .CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .line_start(line_start), .start_col(start_col),
    .advance(advance), .col_addr(col_addr), .slot_zero(slot_zero)
  );

  assign ovl_fetch = advance & slot_zero;

  for (genvar p = 0; p < PLANES; p++) begin : g_plane
    ovl_plane_shift #(.BYTE_W(BYTE_W), .PER_WORD(2)) u_plane (
      .clk(clk), .rst_n(rst_n), .restart(line_start), .advance(advance),
      .load(slot_zero), .plane_en(pen[p]), .byte_in(pbyte[p]),
      .word_bits(pbits[p])
    );
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    pix_lane_sel #(.PIX_W(PIX_W)) u_sel (
      .pixel(word_data[(LANES-1-l)*PIX_W +: PIX_W]),
      .bmask(bmask),
      .code({pbits[1][l], pbits[0][l]}),
      .zero_is_colour(zero_colour),
      .idx(lane_idx[l])
    );
  end

  always_comb begin
    valid_d = take;
    idx0_d  = h_active ? lane_idx[0] : '0;
    idx1_d  = h_active ? lane_idx[1] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
    end else begin
      valid_q <= valid_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx0_q <= '0;
      idx1_q <= '0;
    end else if (take) begin
      idx0_q <= idx0_d;
      idx1_q <= idx1_d;
    end
  end

  assign pix_valid = valid_q;
  assign pix_idx0  = idx0_q;
  assign pix_idx1  = idx1_q;

  AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid && v_active && !line_start) |=> pix_valid); // R11
  AST_NO_VALID_VBLANK: assert property (@(posedge clk) disable iff (!rst_n)
    (!v_active || !word_valid) |=> !pix_valid); // R9
  AST_DROP_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
    line_start |=> !pix_valid); // R8
  AST_BLANK_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !h_active) |=> (pix_idx0 == '0) && (pix_idx1 == '0)); // R10
  AST_FETCH_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    ovl_fetch |-> (word_valid && v_active && h_active)); // R6
  AST_ZERO_COLOUR: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !ovl_ctrl[CTL_ZERO_BMAP]) |=> pix_idx0[PIX_W] && pix_idx1[PIX_W]); // R4
endmodule

// File: tb/ovl_pixel_mixer_bench.sv
module ovl_pixel_mixer_bench;
  typedef struct {
    logic [8:0] a;
    logic [8:0] b;
    string      tag;
  } exp_t;

  logic        clk, rst_n, line_start, v_active, h_active, word_valid;
  logic [8:0]  start_col;
  logic [15:0] word_data;
  logic [7:0]  ovl0_byte, ovl1_byte, read_mask, blink_mask, ovl_ctrl;
  logic [8:0]  col_addr, pix_idx0, pix_idx1;
  logic        ovl_fetch, pix_valid;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  exp_t q[$];

  int         m_cnt;
  logic [7:0] m_b0, m_b1;
  logic [8:0] m_col;

  ovl_pixel_mixer u_ovl_pixel_mixer (
    .clk(clk), .rst_n(rst_n), .line_start(line_start), .start_col(start_col),
    .v_active(v_active), .h_active(h_active), .word_valid(word_valid),
    .word_data(word_data), .ovl0_byte(ovl0_byte), .ovl1_byte(ovl1_byte),
    .read_mask(read_mask), .blink_mask(blink_mask), .ovl_ctrl(ovl_ctrl),
    .col_addr(col_addr), .ovl_fetch(ovl_fetch), .pix_valid(pix_valid),
    .pix_idx0(pix_idx0), .pix_idx1(pix_idx1)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic report();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      checks++; errors++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < 20000", cycles);
      report();
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // monitor: outputs settled since the previous posedge
  always @(negedge clk) begin
    if (rst_n && pix_valid) begin
      checks++;
      if (q.size() == 0) begin
        errors++;
        $display("FAIL R9/R8 unexpected pix_valid actual %0h/%0h expected none", pix_idx0, pix_idx1);
      end else begin
        exp_t e;
        e = q.pop_front();
        if (pix_idx0 !== e.a || pix_idx1 !== e.b) begin
          errors++;
          $display("FAIL %s actual %0h/%0h expected %0h/%0h", e.tag, pix_idx0, pix_idx1, e.a, e.b);
        end
      end
    end
  end

  function automatic logic [8:0] exp_idx(input logic [7:0] pix, input logic [1:0] code);
    logic [7:0] m;
    m = ovl_ctrl[5] ? (read_mask & ~blink_mask) : read_mask;
    if (code != 2'b00 || !ovl_ctrl[6]) return 9'd256 + code;
    return {1'b0, pix & m};
  endfunction

  task automatic new_line(input logic [8:0] sc, input logic with_word);
    @(negedge clk);
    line_start = 1'b1; start_col = sc; word_valid = with_word;
    v_active = 1'b1; h_active = 1'b1; word_data = 16'hffff;
    @(posedge clk);
    m_col = sc; m_cnt = 0;
    @(negedge clk);
    line_start = 1'b0; word_valid = 1'b0;
    chk("R8 start column load", col_addr, sc);
  endtask

  task automatic send(input logic [15:0] d, input logic [7:0] o0, input logic [7:0] o1,
                      input logic vact, input logic hact, input string tag);
    exp_t e;
    logic [1:0] c0, c1;
    logic adv;
    @(negedge clk);
    chk("R7 column address", col_addr, m_col);
    word_valid = 1'b1; word_data = d; ovl0_byte = o0; ovl1_byte = o1;
    v_active = vact; h_active = hact;
    adv = vact && hact;
    #1;
    chk("R6 ovl_fetch", ovl_fetch, (adv && m_cnt == 0));
    if (vact) begin
      if (hact) begin
        if (m_cnt == 0) begin
          m_b0 = ovl_ctrl[2] ? 8'h00 : o0;
          m_b1 = ovl_ctrl[3] ? 8'h00 : o1;
        end
        c0 = {m_b1[0], m_b0[0]};
        c1 = {m_b1[1], m_b0[1]};
        e.a = exp_idx(d[15:8], c0);
        e.b = exp_idx(d[7:0], c1);
        m_b0 = m_b0 >> 2; m_b1 = m_b1 >> 2;
        m_cnt = (m_cnt + 1) % 4;
        m_col = m_col + 9'd1;
      end else begin
        e.a = 9'd0; e.b = 9'd0;
      end
      e.tag = tag;
      q.push_back(e);
    end
    @(posedge clk);
    #1 word_valid = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; line_start = 1'b0; start_col = '0; v_active = 1'b0;
    h_active = 1'b0; word_valid = 1'b0; word_data = '0; ovl0_byte = '0;
    ovl1_byte = '0; read_mask = 8'hff; blink_mask = 8'h00; ovl_ctrl = 8'h40;
    m_cnt = 0; m_b0 = '0; m_b1 = '0; m_col = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R11 reset pix_valid", pix_valid, 0);
    chk("R7 reset col_addr", col_addr, 0);
    rst_n = 1'b1;

    // R1 R3 R6: two overlay bytes across 8 words, bitmap in between
    new_line(9'd5, 1'b0);
    send(16'h1234, 8'b1010_0100, 8'b1100_0000, 1, 1, "R1 R3 R6 word0");
    send(16'hA55A, 8'h00, 8'h00, 1, 1, "R1 R3 R6 word1");
    send(16'h0F70, 8'hff, 8'hff, 1, 1, "R3 R6 word2");
    send(16'h8001, 8'hff, 8'hff, 1, 1, "R3 R6 word3");
    send(16'h3C4D, 8'b0001_1011, 8'b0110_0001, 1, 1, "R3 R6 second byte");
    send(16'h5566, 8'h00, 8'h00, 1, 1, "R3 R6 second byte w1");

    // R9: vertical inactive word leaves overlay and column alone
    send(16'hDEAD, 8'hff, 8'hff, 0, 1, "R9 vinactive");
    send(16'h7788, 8'h00, 8'h00, 1, 1, "R9 R6 after vinactive");
    // R10: blank word gives zero and holds state
    send(16'hBEEF, 8'hff, 8'hff, 1, 0, "R10 hblank zero");
    send(16'h99AA, 8'h00, 8'h00, 1, 1, "R10 R6 after hblank");

    // R2 read mask, then blink
    new_line(9'd40, 1'b0);
    read_mask = 8'h0f;
    send(16'hF3C7, 8'h00, 8'h00, 1, 1, "R2 read mask");
    ovl_ctrl = 8'h60; blink_mask = 8'h03;
    send(16'hF3C7, 8'h00, 8'h00, 1, 1, "R2 blink mask");
    ovl_ctrl = 8'h40;
    send(16'hF3C7, 8'h00, 8'h00, 1, 1, "R2 blink off");
    read_mask = 8'hff;

    // R4 zero code is colour
    new_line(9'd100, 1'b0);
    ovl_ctrl = 8'h00;
    send(16'h1122, 8'b0000_0010, 8'h00, 1, 1, "R4 zero is colour");
    send(16'h3344, 8'h00, 8'h00, 1, 1, "R4 zero is colour w1");

    // R5 plane disables
    new_line(9'd200, 1'b0);
    ovl_ctrl = 8'h44;
    send(16'h1122, 8'hff, 8'hff, 1, 1, "R5 plane0 off");
    new_line(9'd201, 1'b0);
    ovl_ctrl = 8'h48;
    send(16'h1122, 8'hff, 8'hff, 1, 1, "R5 plane1 off");
    ovl_ctrl = 8'h40;

    // R7 wrap
    new_line(9'd510, 1'b0);
    send(16'h0102, 8'h00, 8'h00, 1, 1, "R7 wrap w0");
    send(16'h0304, 8'h00, 8'h00, 1, 1, "R7 wrap w1");
    send(16'h0506, 8'h00, 8'h00, 1, 1, "R7 wrap w2");
    @(negedge clk);
    chk("R7 wrapped column", col_addr, 1);

    // R8 word at line start dropped, overlay restarts mid-byte
    send(16'h0708, 8'hff, 8'hff, 1, 1, "R8 pre");
    new_line(9'd7, 1'b1);
    send(16'h090A, 8'b0000_0001, 8'h00, 1, 1, "R8 restarted overlay");

    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R11 all results drained", q.size(), 0);
    report();
  end
endmodule